// File: doc/BRIEF.md
# SPI command-stream engine

This block is an SPI master that does not rely on memory-mapped control. It executes a stream of 16-bit instructions that arrive over a valid/ready command channel. The instructions drive eight chip-select lines, set the SCLK divider, the mode bits and the word length, shift data words and insert timed waits. A sync instruction publishes an 8-bit marker, so the producer can tell how far the stream has progressed.

Transmit words come in on a valid/ready stream. Received words leave on another valid/ready stream, right-aligned and zero-extended to 32 bits. If a data stream cannot keep up, the engine pauses. SCLK stops between words and the chip selects keep their state. No bit is lost. Counts are encoded as the value minus one. Instruction word: opcode [15:12], first argument [11:8], second argument [7:0].

Top module: `spi_cmd_engine`

## Requirements
- R1: One instruction is consumed per command handshake, and `cmd_ready` is high only while the engine waits for an instruction. Opcodes 5 to 15 are consumed and change no output.
- R2: After reset: `cs_n` all ones, `sclk` 0, `sdo` 0, `sdo_oe` 1, `sync_id` 0, `rx_valid` 0, `cmd_ready` 1. Internal settings after reset are divider 0, config 0, word length 8 and inversion mask 0.
- R3: Opcode 1 drives `cs_n` with its second argument XOR the current inversion mask. An argument of 0xFF with a zero mask releases every line.
- R4: Opcode 4 stores its second argument as the per-line inversion mask. `cs_n` changes only when an opcode 1 instruction executes.
- R5: Opcode 2 writes a setting selected by the first argument: 0 = divider, 1 = config, 2 = word length. A word length outside 1..32 is ignored.
- R6: Opcode 0 moves (second argument + 1) words. Each word produces 2×length SCLK edges, and SCLK rests at CPOL between words.
- R7: Shifting is MSB-first. CPHA=0 samples on the leading edge and CPHA=1 samples on the trailing edge. With `sdi` tied to `sdo`, the received word equals the transmitted word masked to the word length.
- R8: Opcode 3 with first argument 1 waits (second argument + 1) SCLK periods. One SCLK half-period is (divider + 1) clock cycles, so the wait keeps `cmd_ready` low for 2·(n+1)·(div+1) cycles.
- R9: Opcode 3 with first argument 0 loads its second argument into `sync_id` and raises `sync_pulse` for one cycle.
- R10: In a write transfer (first argument bit 0) with no transmit word available, SCLK stays still and `cs_n` is held until a word arrives.
- R11: In a read transfer (first argument bit 1), a received word that is not yet accepted blocks the next word. SCLK stays still until `rx_ready`.
- R12: With config bit 2 (three-wire) set, `sdo_oe` is 0 during a read-only transfer. Otherwise it is 1.
- R13: Outside the bits of a write transfer, `sdo` rests at config bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Instruction available |
| cmd_ready | output | 1 | Engine accepts an instruction |
| cmd_data | input | 16 | Instruction word |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken |
| tx_data | input | 32 | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 32 | Received word, right-aligned, zero-extended |
| sync_pulse | output | 1 | One-cycle marker event |
| sync_id | output | 8 | Last published marker |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data pin |
| sdi | input | 1 | Serial data in |
| cs_n | output | 8 | Chip-select lines |

## Verification
The hardest situation to reach from the ports is a transfer frozen in the middle, with one word done and the next held back. The stimulus gets there by starving the transmit stream, or by holding `rx_ready` low across a two-word read, and then counting SCLK edges during a long idle window before releasing the stream. Bit order and edge choice are exercised through a table of mode, length and divider settings, with `sdi` looped back to `sdo`. Sleep length is measured as the number of cycles for which `cmd_ready` stays low.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [3:0] OP_XFER  = 4'd0;
  localparam logic [3:0] OP_CS    = 4'd1;
  localparam logic [3:0] OP_WREG  = 4'd2;
  localparam logic [3:0] OP_MISC  = 4'd3;
  localparam logic [3:0] OP_CSINV = 4'd4;

  localparam logic [3:0] SEL_DIV  = 4'd0;
  localparam logic [3:0] SEL_CFG  = 4'd1;
  localparam logic [3:0] SEL_BITS = 4'd2;

  localparam logic [3:0] MISC_MARK  = 4'd0;
  localparam logic [3:0] MISC_PAUSE = 4'd1;

  localparam int CFG_CPHA = 0;
  localparam int CFG_CPOL = 1;
  localparam int CFG_3W   = 2;
  localparam int CFG_IDLE = 3;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] a1;
    logic [7:0] a2;
  } instr_t;

  typedef enum logic [1:0] {ST_FETCH, ST_XFER, ST_SLEEP} seq_e;
endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = en && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (!en || tick)  cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // R8: half-period counter never runs past the divider value
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt_q <= div));
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int DW = 32,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic          wr,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          idle_lvl,
  input  logic [BW-1:0] nbits,
  input  logic [DW-1:0] txw,
  input  logic          sdi,
  output logic          busy,
  output logic          done,
  output logic          sclk,
  output logic          sdo,
  output logic [DW-1:0] rxw
);
  localparam int EW = BW + 1;

  logic          busy_q, done_q, sclk_q, sdo_q, wr_q, cpha_q;
  logic [DW-1:0] out_q, in_q, rx_q, aligned;
  logic [EW-1:0] edge_q;
  logic [BW-1:0] nb_q;
  logic [BW:0]   shamt;
  logic          lead, last, smp;

  assign shamt   = (BW+1)'(DW) - {1'b0, nbits};
  assign aligned = txw << shamt;
  assign lead    = ~edge_q[0];
  assign last    = (edge_q == ({nb_q, 1'b0} - 1'b1));
  assign smp     = (lead == ~cpha_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; done_q <= 1'b0; sclk_q <= 1'b0; sdo_q <= 1'b0;
      wr_q <= 1'b0; cpha_q <= 1'b0; out_q <= '0; in_q <= '0; rx_q <= '0;
      edge_q <= '0; nb_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sclk_q <= cpol;
        if (start) begin
          busy_q <= 1'b1;
          edge_q <= '0;
          nb_q   <= nbits;
          wr_q   <= wr;
          cpha_q <= cpha;
          in_q   <= '0;
          if (!cpha) begin
            sdo_q <= wr ? aligned[DW-1] : idle_lvl;
            out_q <= aligned << 1;
          end else begin
            sdo_q <= idle_lvl;
            out_q <= aligned;
          end
        end else begin
          sdo_q <= idle_lvl;
        end
      end else if (tick) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (smp) begin
          in_q <= {in_q[DW-2:0], sdi};
        end else if (!last) begin
          sdo_q <= wr_q ? out_q[DW-1] : idle_lvl;
          out_q <= out_q << 1;
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= cpha_q ? {in_q[DW-2:0], sdi} : in_q;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign sclk = sclk_q;
  assign sdo  = sdo_q;
  assign rxw  = rx_q;

  // R6: edge index stays inside the 2*length window of the word
  a_r6_edge_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (edge_q < {nb_q, 1'b0}));
  // R6: after the last edge the clock is back at its resting level
  a_r6_idle_restore: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (sclk_q == cpol));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int NCS   = 8,
  parameter int DW    = 32,
  parameter int DIV_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [15:0]    cmd_data,
  input  logic           tx_valid,
  output logic           tx_ready,
  input  logic [DW-1:0]  tx_data,
  output logic           rx_valid,
  input  logic           rx_ready,
  output logic [DW-1:0]  rx_data,
  output logic           sync_pulse,
  output logic [7:0]     sync_id,
  output logic           sclk,
  output logic           sdo,
  output logic           sdo_oe,
  input  logic           sdi,
  output logic [NCS-1:0] cs_n
);
  localparam int BW = $clog2(DW + 1);

  instr_t            ins;
  seq_e              st_q;
  logic              accept, start, tick, tick_en;
  logic              sh_busy, sh_done;
  logic [DW-1:0]     sh_rx;
  logic [DIV_W-1:0]  div_q;
  logic [3:0]        cfg_q;
  logic [BW-1:0]     nbits_q;
  logic [NCS-1:0]    inv_q, cs_q;
  logic [7:0]        sid_q, left_q, slp_left_q;
  logic              syncp_q, xwr_q, xrd_q, xdone_q, rxv_q, oe_q, slp_half_q;
  logic [DW-1:0]     rxd_q;

  assign ins       = cmd_data;
  assign cmd_ready = (st_q == ST_FETCH);
  assign accept    = cmd_valid && cmd_ready;
  assign start     = (st_q == ST_XFER) && !sh_busy && !sh_done && !rxv_q &&
                     !xdone_q && (!xwr_q || tx_valid);
  assign tx_ready  = start && xwr_q;
  assign tick_en   = sh_busy || (st_q == ST_SLEEP);

  spi_cmd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(tick_en), .div(div_q), .tick(tick)
  );

  spi_cmd_shift #(.DW(DW), .BW(BW)) u_shift (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .wr(xwr_q),
    .cpol(cfg_q[CFG_CPOL]), .cpha(cfg_q[CFG_CPHA]), .idle_lvl(cfg_q[CFG_IDLE]),
    .nbits(nbits_q), .txw(tx_data), .sdi(sdi),
    .busy(sh_busy), .done(sh_done), .sclk(sclk), .sdo(sdo), .rxw(sh_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_FETCH; div_q <= '0; cfg_q <= '0; nbits_q <= BW'(8);
      inv_q <= '0; cs_q <= '1; sid_q <= '0; syncp_q <= 1'b0;
      xwr_q <= 1'b0; xrd_q <= 1'b0; left_q <= '0; xdone_q <= 1'b0;
      rxv_q <= 1'b0; rxd_q <= '0; oe_q <= 1'b1;
      slp_left_q <= '0; slp_half_q <= 1'b0;
    end else begin
      syncp_q <= 1'b0;
      if (rxv_q && rx_ready) rxv_q <= 1'b0;
      case (st_q)
        ST_FETCH: begin
          if (accept) begin
            case (ins.op)
              OP_XFER: begin
                xwr_q   <= ins.a1[0];
                xrd_q   <= ins.a1[1];
                left_q  <= ins.a2;
                xdone_q <= 1'b0;
                oe_q    <= !(cfg_q[CFG_3W] && !ins.a1[0]);
                st_q    <= ST_XFER;
              end
              OP_CS:    cs_q  <= ins.a2[NCS-1:0] ^ inv_q;
              OP_CSINV: inv_q <= ins.a2[NCS-1:0];
              OP_WREG: begin
                case (ins.a1)
                  SEL_DIV:  div_q <= DIV_W'(ins.a2);
                  SEL_CFG:  cfg_q <= ins.a2[3:0];
                  SEL_BITS: if (ins.a2 >= 8'd1 && ins.a2 <= 8'(DW))
                              nbits_q <= BW'(ins.a2);
                  default: ;
                endcase
              end
              OP_MISC: begin
                if (ins.a1 == MISC_MARK) begin
                  sid_q   <= ins.a2;
                  syncp_q <= 1'b1;
                end else if (ins.a1 == MISC_PAUSE) begin
                  slp_left_q <= ins.a2;
                  slp_half_q <= 1'b0;
                  st_q       <= ST_SLEEP;
                end
              end
              default: ;
            endcase
          end
        end
        ST_XFER: begin
          if (sh_done) begin
            if (xrd_q) begin
              rxv_q <= 1'b1;
              rxd_q <= sh_rx;
            end
            if (left_q == 8'd0) xdone_q <= 1'b1;
            else                left_q  <= left_q - 1'b1;
          end else if (xdone_q && !rxv_q) begin
            st_q <= ST_FETCH;
            oe_q <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (tick) begin
            slp_half_q <= ~slp_half_q;
            if (slp_half_q) begin
              if (slp_left_q == 8'd0) st_q <= ST_FETCH;
              else                    slp_left_q <= slp_left_q - 1'b1;
            end
          end
        end
        default: st_q <= ST_FETCH;
      endcase
    end
  end

  assign cs_n       = cs_q;
  assign sync_id    = sid_q;
  assign sync_pulse = syncp_q;
  assign rx_valid   = rxv_q;
  assign rx_data    = rxd_q;
  assign sdo_oe     = oe_q;

  // R4: the lines only move when an assert instruction was taken
  a_r4_cs_only_on_assert: assert property (@(posedge clk) disable iff (rst)
    !$stable(cs_q) |-> $past(accept && ins.op == OP_CS));
  // R9: every marker pulse traces back to an accepted sync instruction
  a_r9_mark_cause: assert property (@(posedge clk) disable iff (rst)
    syncp_q |-> $past(accept && ins.op == OP_MISC && ins.a1 == MISC_MARK));
  // R11: an unaccepted received word is held steady
  a_r11_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (rxv_q && !rx_ready) |=> (rxv_q && $stable(rxd_q)));
  // R10: no word starts while the transmit stream is empty
  a_r10_tx_gate: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER && xwr_q && !tx_valid && !sh_busy) |=> !sh_busy);
  // R12: the data pin is released only inside a three-wire transfer
  a_r12_oe_scope: assert property (@(posedge clk) disable iff (rst)
    !oe_q |-> (st_q == ST_XFER && cfg_q[CFG_3W]));
endmodule

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, cmd_ready, tx_valid, tx_ready, rx_valid, rx_ready;
  logic [15:0] cmd_data;
  logic [31:0] tx_data, rx_data;
  logic        sync_pulse, sclk, sdo, sdo_oe, sdi;
  logic [7:0]  sync_id, cs_n;

  int n_checks = 0;
  int n_bad = 0;
  int sclk_edges = 0;
  int rx_cnt = 0;
  int sync_cnt = 0;
  logic [31:0] rx_buf [0:15];

  always #4 clk = ~clk;
  assign sdi = sdo;

  spi_cmd_engine dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sync_pulse(sync_pulse), .sync_id(sync_id),
    .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi), .cs_n(cs_n)
  );

  // {cfg[3:0], bits[5:0], div[7:0], tx[31:0], expected rx[31:0]}
  localparam logic [81:0] VEC [0:6] = '{
    {4'h0, 6'd8,  8'd0, 32'h000000A5, 32'h000000A5},
    {4'h1, 6'd8,  8'd1, 32'h0000003C, 32'h0000003C},
    {4'h2, 6'd16, 8'd2, 32'hFFFF1234, 32'h00001234},
    {4'h3, 6'd32, 8'd0, 32'hDEADBEEF, 32'hDEADBEEF},
    {4'h0, 6'd1,  8'd3, 32'h00000003, 32'h00000001},
    {4'h3, 6'd13, 8'd0, 32'h0000ABCD, 32'h00000BCD},
    {4'h8, 6'd12, 8'd0, 32'h0000080F, 32'h0000080F}
  };

  always @(sclk) if (!rst) sclk_edges++;

  always begin
    @(negedge clk);
    #3;
    if (!rst && rx_valid && rx_ready) begin
      rx_buf[rx_cnt % 16] = rx_data;
      rx_cnt++;
    end
    if (!rst && sync_pulse) sync_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_sync(input int target);
    while (sync_cnt < target) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_checks + 1, n_bad + 1);
    $finish;
  end

  initial begin
    int e0, r0, s0, n;
    logic [81:0] v;
    rst = 1'b1; cmd_valid = 1'b0; cmd_data = '0;
    tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk("R2 cs_n", 32'(cs_n), 32'hFF);
    chk("R2 sclk", 32'(sclk), 32'h0);
    chk("R2 sdo", 32'(sdo), 32'h0);
    chk("R2 sdo_oe", 32'(sdo_oe), 32'h1);
    chk("R2 sync_id", 32'(sync_id), 32'h0);
    chk("R2 rx_valid", 32'(rx_valid), 32'h0);
    chk("R2 cmd_ready", 32'(cmd_ready), 32'h1);

    for (int i = 0; i < 7; i++) begin
      v = VEC[i];
      send({8'h21, 4'h0, v[81:78]});
      send({8'h22, 2'b00, v[77:72]});
      send({8'h20, v[71:64]});
      tx_data  = v[63:32];
      tx_valid = 1'b1;
      send(16'h10FE);
      e0 = sclk_edges; r0 = rx_cnt; s0 = sync_cnt;
      send(16'h0300);
      send(16'h10FF);
      send({8'h30, 8'(i + 16)});
      wait_sync(s0 + 1);
      @(negedge clk);
      chk("R7 loopback word", rx_buf[r0 % 16], v[31:0]);
      chk("R6 edge count", 32'(sclk_edges - e0), 32'(2 * int'(v[77:72])));
      chk("R6 sclk rest", 32'(sclk), 32'(v[79]));
      chk("R9 sync_id", 32'(sync_id), 32'(i + 16));
      chk("R13 sdo rest", 32'(sdo), 32'(v[81]));
      tx_valid = 1'b0;
    end
    send(16'h2100);
    send(16'h2000);

    // R4: inversion waits for the next assert
    send(16'h4001);
    chk("R4 mask not yet applied", 32'(cs_n), 32'hFF);
    send(16'h10FF);
    chk("R4 mask applied", 32'(cs_n), 32'hFE);
    send(16'h4000);
    send(16'h10FF);
    chk("R4 mask cleared", 32'(cs_n), 32'hFF);

    // R3: plain select pattern
    send(16'h10A5);
    chk("R3 select pattern", 32'(cs_n), 32'hA5);
    send(16'h10FF);

    // R1: undefined opcodes are consumed without effect
    send(16'h5A12);
    send(16'hF0FE);
    chk("R1 unknown op cs_n", 32'(cs_n), 32'hFF);
    chk("R1 unknown op ready", 32'(cmd_ready), 32'h1);

    // R8: wait length
    send(16'h2002);
    send(16'h3101);
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
    chk("R8 sleep div2 n1", 32'(n), 32'd12);
    send(16'h2000);
    send(16'h3100);
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
    chk("R8 sleep div0 n0", 32'(n), 32'd2);

    // R5: out-of-range word lengths are ignored
    send(16'h2208);
    send(16'h2200);
    send(16'h2228);
    tx_data = 32'h000000C3; tx_valid = 1'b1;
    e0 = sclk_edges; s0 = sync_cnt;
    send(16'h0100);
    send(16'h3041);
    wait_sync(s0 + 1);
    chk("R5 length kept at 8", 32'(sclk_edges - e0), 32'd16);
    tx_valid = 1'b0;

    // R10: empty transmit stream stalls the clock, select held
    send(16'h10FE);
    e0 = sclk_edges; s0 = sync_cnt;
    send(16'h0101);
    repeat (40) @(negedge clk);
    chk("R10 no edges while starved", 32'(sclk_edges - e0), 32'd0);
    chk("R10 cs held", 32'(cs_n), 32'hFE);
    chk("R10 busy", 32'(cmd_ready), 32'h0);
    tx_data = 32'h5A; tx_valid = 1'b1;
    send(16'h10FF);
    send(16'h3055);
    wait_sync(s0 + 1);
    chk("R10 resumed edges", 32'(sclk_edges - e0), 32'd32);
    tx_valid = 1'b0;

    // R11/R12/R13: three-wire read with a blocked consumer
    send(16'h210C);
    @(negedge clk);
    chk("R13 sdo idles high", 32'(sdo), 32'h1);
    rx_ready = 1'b0;
    send(16'h10FE);
    e0 = sclk_edges; r0 = rx_cnt; s0 = sync_cnt;
    send(16'h0201);
    repeat (60) @(negedge clk);
    chk("R11 one word then stall", 32'(sclk_edges - e0), 32'd16);
    chk("R12 pin released", 32'(sdo_oe), 32'h0);
    chk("R11 word pending", 32'(rx_valid), 32'h1);
    chk("R11 pending data", rx_data, 32'h000000FF);
    rx_ready = 1'b1;
    send(16'h10FF);
    send(16'h3066);
    wait_sync(s0 + 1);
    @(negedge clk);
    chk("R11 words delivered", 32'(rx_cnt - r0), 32'd2);
    chk("R11 second word", rx_buf[(r0 + 1) % 16], 32'h000000FF);
    chk("R11 total edges", 32'(sclk_edges - e0), 32'd32);
    chk("R12 pin driven again", 32'(sdo_oe), 32'h1);
    chk("R9 last marker", 32'(sync_id), 32'h66);

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule